// File: doc/BRIEF.md
# Interrupt Break Request Controller

This block decides when a single-wire bus slave should signal the host with an interrupt break. A row of event strobes sets sticky bits in a status register. When a bit is set whose source is enabled, and the master interrupt enable is on, the block raises a break request toward the bus transmitter. The block then keeps raising a request after every finished instruction frame that did not touch the status register. This continues until the host reads status. That read clears every status bit in one step.

Requests are only launched at a frame boundary or while the bus is idle, never in the middle of a frame. Each request is held until the transmitter acknowledges it, and at most one is outstanding. A trigger that arrives while a request is outstanding is remembered and is launched after the acknowledge. A configuration load strobe, issued at power-on wake and at soft reset, puts the control register into its default state taken from the nonvolatile configuration bits, and flushes the status and request state. The host can read and write the control register.

Top module: `intr_break_req`

## Requirements
- R1: Status bit i is set one cycle after `evt[i]` is high and stays set until the status register is cleared.
- R2: A cycle with `stat_rd` high clears every status bit at once. An event strobe in that same cycle is still recorded in the status register.
- R3: An event on a source whose enable bit is set, while the master enable is set, leads to a break request. An event on a disabled source, or any event while the master enable is clear, raises no request, although the status bit is still set.
- R4: When `frame_done` is high with `frame_stat` low while an enabled status bit is set and the master enable is set, a new request is raised.
- R5: A finished frame with `frame_stat` high raises no request.
- R6: `brk_req` rises only at the clock edge that closes a cycle in which `bus_idle` or `frame_done` was high. A pending trigger waits until that happens.
- R7: `brk_req` stays high until a cycle with `brk_ack` high and drops after it. A trigger that arrives while a request is outstanding is launched after the acknowledge, as one more request.
- R8: A control write with `ctl_wr` stores `ctl_wdata` into `ctl_q` in the next cycle. The layout is: bits [NSRC-1:0] are the per-source enables, bit NSRC is the master enable, and bit NSRC+1 is the auto-sleep enable.
- R9: `cfg_load` sets every source enable, sets the master enable to `cfg_int_en` and the auto-sleep enable to `cfg_auto_sleep`, and clears the status bits, any pending trigger and `brk_req`. It takes priority over `ctl_wr`.
- R10: After reset, `ctl_q`, `stat_q` and `brk_req` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load control defaults and flush state |
| cfg_int_en | input | 1 | Default value of the master interrupt enable |
| cfg_auto_sleep | input | 1 | Default value of the auto-sleep enable |
| ctl_wr | input | 1 | Host write strobe for the control register |
| ctl_wdata | input | NSRC+2 | Control write data |
| ctl_q | output | NSRC+2 | Control register value |
| evt | input | NSRC | Status event strobes, one per source |
| stat_rd | input | 1 | Host read of the status register (clears it) |
| frame_done | input | 1 | An instruction frame has completed |
| frame_stat | input | 1 | The completed frame accessed the status register |
| bus_idle | input | 1 | The bus is idle between frames |
| stat_q | output | NSRC | Status register value |
| brk_req | output | 1 | Request to transmit a break |
| brk_ack | input | 1 | Transmitter has taken the request |

## Verification
Two pairs of functions can land in the same cycle. The first pair is the clear-on-read and a new event. This is provoked by driving `stat_rd` and an `evt` bit together, and is judged by the new bit surviving in `stat_q` and by a request being raised for it. The second pair is an acknowledge and a fresh trigger. This is provoked by driving `brk_ack` in the same cycle as an enabled event. It is judged by `brk_req` first dropping for a cycle and then rising again at the next idle cycle, so that one request is never stretched into two.

// File: rtl/intr_brk_pkg.sv
package intr_brk_pkg;

  // control register layout, relative to the number of sources
  function automatic int unsigned gie_pos(input int unsigned nsrc);
    return nsrc;
  endfunction

  function automatic int unsigned aslp_pos(input int unsigned nsrc);
    return nsrc + 1;
  endfunction

endpackage

// File: rtl/intr_ctl_reg.sv
module intr_ctl_reg
  import intr_brk_pkg::*;
#(
  parameter int unsigned NSRC = 4,
  localparam int unsigned CW  = NSRC + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic          cfg_int_en,
  input  logic          cfg_auto_sleep,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] ctl_q
);

  localparam int unsigned GIE  = gie_pos(NSRC);
  localparam int unsigned ASLP = aslp_pos(NSRC);

  logic [CW-1:0] dflt;
  logic [CW-1:0] ctl_d;
  logic          ctl_en;

  always_comb begin
    dflt             = '0;
    dflt[NSRC-1:0]   = '1;
    dflt[GIE]        = cfg_int_en;
    dflt[ASLP]       = cfg_auto_sleep;
  end

  always_comb begin
    ctl_en = cfg_load | wr_en;
    ctl_d  = cfg_load ? dflt : wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !cfg_load) |=> (ctl_q == $past(wr_data)));

  a_r9_default_load: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (ctl_q[NSRC-1:0] == '1 && ctl_q[GIE] == $past(cfg_int_en)
                  && ctl_q[ASLP] == $past(cfg_auto_sleep)));

endmodule

// File: rtl/intr_stat_reg.sv
module intr_stat_reg #(
  parameter int unsigned NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            rd_clr,
  input  logic [NSRC-1:0] evt,
  output logic [NSRC-1:0] stat_q
);

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic bit_d;
    logic bit_en;

    always_comb begin
      bit_en = flush | rd_clr | evt[i];
      if (flush)       bit_d = 1'b0;
      else if (evt[i]) bit_d = 1'b1;
      else             bit_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stat_q[i] <= 1'b0;
      else if (bit_en) stat_q[i] <= bit_d;
    end
  end

  a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr && !flush) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  a_r2_read_keeps_new: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !flush) |=> (stat_q == $past(evt)));

  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (stat_q == '0));

endmodule

// File: rtl/intr_brk_arb.sv
module intr_brk_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic rd_clr,
  input  logic trig_evt,
  input  logic trig_frame,
  input  logic boundary,
  input  logic brk_ack,
  output logic brk_req
);

  logic owe_q, owe_d;
  logic req_d;
  logic want;
  logic launch;

  always_comb begin
    want   = (owe_q & ~rd_clr) | trig_evt | trig_frame;
    launch = want & ~brk_req & boundary;
    if (flush) begin
      owe_d = 1'b0;
      req_d = 1'b0;
    end else begin
      owe_d = want & ~launch;
      req_d = launch | (brk_req & ~brk_ack);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owe_q   <= 1'b0;
      brk_req <= 1'b0;
    end else begin
      owe_q   <= owe_d;
      brk_req <= req_d;
    end
  end

  a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && !brk_ack && !flush) |=> brk_req);

  a_r7_drop_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && brk_ack) |=> !brk_req);

  a_r6_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_req) |-> $past(boundary));

  a_r9_flush_drops: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !brk_req);

endmodule

// File: rtl/intr_break_req.sv
module intr_break_req
  import intr_brk_pkg::*;
#(
  parameter int unsigned NSRC = 4,
  localparam int unsigned CW  = NSRC + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_load,
  input  logic            cfg_int_en,
  input  logic            cfg_auto_sleep,
  input  logic            ctl_wr,
  input  logic [CW-1:0]   ctl_wdata,
  output logic [CW-1:0]   ctl_q,
  input  logic [NSRC-1:0] evt,
  input  logic            stat_rd,
  input  logic            frame_done,
  input  logic            frame_stat,
  input  logic            bus_idle,
  output logic [NSRC-1:0] stat_q,
  output logic            brk_req,
  input  logic            brk_ack
);

  localparam int unsigned GIE = gie_pos(NSRC);

  logic [NSRC-1:0] src_en;
  logic            gie;
  logic            trig_evt;
  logic            trig_frame;
  logic            boundary;

  intr_ctl_reg #(.NSRC(NSRC)) u_ctl (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_load       (cfg_load),
    .cfg_int_en     (cfg_int_en),
    .cfg_auto_sleep (cfg_auto_sleep),
    .wr_en          (ctl_wr),
    .wr_data        (ctl_wdata),
    .ctl_q          (ctl_q)
  );

  intr_stat_reg #(.NSRC(NSRC)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (cfg_load),
    .rd_clr (stat_rd),
    .evt    (evt),
    .stat_q (stat_q)
  );

  always_comb begin
    src_en     = ctl_q[NSRC-1:0];
    gie        = ctl_q[GIE];
    trig_evt   = gie & |(evt & src_en);
    trig_frame = gie & frame_done & ~frame_stat & |(stat_q & src_en);
    boundary   = bus_idle | frame_done;
  end

  intr_brk_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (cfg_load),
    .rd_clr     (stat_rd),
    .trig_evt   (trig_evt),
    .trig_frame (trig_frame),
    .boundary   (boundary),
    .brk_ack    (brk_ack),
    .brk_req    (brk_req)
  );

  // R3: with the master enable clear, no new request can start
  a_r3_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie && !brk_req && !u_arb.owe_q) |=> !brk_req);

endmodule

// File: tb/sim_intr_break_req.sv
module sim_intr_break_req;

  localparam int unsigned NSRC = 4;
  localparam int unsigned CW   = NSRC + 2;
  localparam int unsigned NV   = 14;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cfg_load, cfg_int_en, cfg_auto_sleep;
  logic            ctl_wr;
  logic [CW-1:0]   ctl_wdata, ctl_q;
  logic [NSRC-1:0] evt, stat_q;
  logic            stat_rd, frame_done, frame_stat, bus_idle;
  logic            brk_req, brk_ack;

  int checks   = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  intr_break_req #(.NSRC(NSRC)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_int_en(cfg_int_en),
    .cfg_auto_sleep(cfg_auto_sleep), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_q(ctl_q), .evt(evt), .stat_rd(stat_rd), .frame_done(frame_done),
    .frame_stat(frame_stat), .bus_idle(bus_idle), .stat_q(stat_q),
    .brk_req(brk_req), .brk_ack(brk_ack)
  );

  // {evt, rd, fdone, fstat, idle, ack, exp_stat, exp_req}
  localparam logic [13:0] VEC [NV] = '{
    {4'b0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0001, 1'b0},
    {4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0001, 1'b0},
    {4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0001, 1'b1},
    {4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0001, 1'b1},
    {4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0001, 1'b0},
    {4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0001, 1'b1},
    {4'b0010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0011, 1'b0},
    {4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0011, 1'b1},
    {4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0011, 1'b0},
    {4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0000, 1'b0},
    {4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0},
    {4'b0100, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0100, 1'b1},
    {4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0100, 1'b0},
    {4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0}
  };

  function automatic string row_tag(input int i);
    case (i)
      0, 1:   return "R1/R6 event waits for idle";
      2:      return "R3/R6 request at idle";
      3:      return "R7 hold without ack";
      4:      return "R7 drop on ack";
      5:      return "R4 re-request after frame";
      6:      return "R7 trigger during outstanding";
      7:      return "R7 queued request launched";
      8:      return "R7 second ack";
      9:      return "R2/R5 read frame clears";
      10:     return "R4 nothing set no request";
      11:     return "R2 event same cycle as read";
      12:     return "R7 ack";
      default: return "R2 read clear";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cfg_load = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0; evt = '0;
    stat_rd = 1'b0; frame_done = 1'b0; frame_stat = 1'b0;
    bus_idle = 1'b0; brk_ack = 1'b0;
  endtask

  // inputs already set at a negedge; advance one cycle and clear them
  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_int_en = 1'b0; cfg_auto_sleep = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 ctl after reset", 32'(ctl_q), 0);
    check("R10 stat after reset", 32'(stat_q), 0);
    check("R10 req after reset", 32'(brk_req), 0);

    // R9: default load with both defaults set, write at same time loses
    cfg_load = 1'b1; cfg_int_en = 1'b1; cfg_auto_sleep = 1'b1;
    ctl_wr = 1'b1; ctl_wdata = 6'h05;
    step();
    check("R9 default load", 32'(ctl_q), 32'h3F);

    for (int i = 0; i < NV; i++) begin
      {evt, stat_rd, frame_done, frame_stat, bus_idle, brk_ack} = VEC[i][13:5];
      step();
      check(row_tag(i), 32'(stat_q), 32'(VEC[i][4:1]));
      check(row_tag(i), 32'(brk_req), 32'(VEC[i][0]));
    end

    // R8: disable source 0
    ctl_wr = 1'b1; ctl_wdata = 6'b11_1110;
    step();
    check("R8 control write", 32'(ctl_q), 32'h3E);
    evt = 4'b0001; bus_idle = 1'b1;
    step();
    check("R3 disabled source sets status", 32'(stat_q), 1);
    check("R3 disabled source no request", 32'(brk_req), 0);

    // R3: master enable off
    ctl_wr = 1'b1; ctl_wdata = 6'b10_1111;
    step();
    check("R8 control write master off", 32'(ctl_q), 32'h2F);
    evt = 4'b0010; bus_idle = 1'b1;
    step();
    check("R3 master off status", 32'(stat_q), 3);
    check("R3 master off no request", 32'(brk_req), 0);
    frame_done = 1'b1;
    step();
    check("R4 master off no re-request", 32'(brk_req), 0);

    // R9: reload with master on, auto-sleep off; clears status
    cfg_load = 1'b1; cfg_int_en = 1'b1; cfg_auto_sleep = 1'b0;
    step();
    check("R9 reload control", 32'(ctl_q), 32'h1F);
    check("R9 reload clears status", 32'(stat_q), 0);

    // R9: flush of a pending request and trigger
    evt = 4'b1000;
    step();
    check("R6 mid-frame no request", 32'(brk_req), 0);
    cfg_load = 1'b1;
    step();
    bus_idle = 1'b1;
    step();
    check("R9 pending flushed", 32'(brk_req), 0);
    check("R9 status flushed", 32'(stat_q), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule